// File: doc/BRIEF.md
# Keyed Clock-Synthesiser Register Bank

This block is an indexed register bank that holds the programming of two clock synthesisers: one for the memory clock and one programmable video clock. Software selects a register with an 8-bit index and strobes either a write or a read. A key register at index 8 can always be accessed. Every index above 8 is reachable only while the key holds 0x06.

Each synthesiser has three divider fields. The N and R fields share one byte and the M field sits in the next index. A command register carries the flag that halves the pixel clock. One index returns a fixed four-byte identification sequence, one byte per read strobe, and the sequence wraps. Separately from the register path, the two clock-select bits taken from the display's miscellaneous output register are decoded into a report of which clock source is active. This block does not compute any frequency.

Reads are combinational from the index. A read strobe is only needed for its side effect, which is advancing the sequence pointer.

Top module: `seqx_clk_regs`

## Requirements
- R1: After reset the key, every divider field, the command register and the sequence pointer are zero, so index 8 reads 0x00 and `halve_pclk` is 0.
- R2: Index 8 is always readable and writable, and it reads back the last value written.
- R3: While the key is not 0x06, a write to any index above 8 is dropped. After unlocking, that index still reads its earlier value.
- R4: While the key is not 0x06, a read of an index above 8 returns 0x00 if the index is below 0x1B, and returns the index value itself otherwise.
- R5: Index 0x10 holds the memory synthesiser N in bits 4:0 and R in bits 7:5, and reads back as the reassembled byte. Index 0x11 holds M in bits 6:0 and reads bit 7 as 0.
- R6: Index 0x12 holds the video synthesiser N in bits 4:0 and R in bits 7:5. Index 0x13 holds its M in bits 6:0. The field layout and readback are the same as in R5.
- R7: Index 0x15 is a full 8-bit command register, and its bit 4 drives `halve_pclk`.
- R8: While unlocked, successive read strobes of index 0x17 return 0x7B, 0xC0, 0x00, 0xDA and then wrap. The pointer advances only on an unlocked read strobe of 0x17, so locked reads of 0x17 leave it unchanged.
- R9: `clk_src` is 0 (fixed 25.175 MHz) when `misc_clk_sel` is 0, is 1 (fixed 28.322 MHz) when it is 1, and is 2 (programmable synthesiser) when it is 2 or 3.
- R10: While unlocked, indices with no register (for example 0x14, 0x16, 0x20 and indices 0 to 7) read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx | input | 8 | Register index |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (advances the sequence pointer at index 0x17) |
| rdata | output | 8 | Read data for `idx` (combinational) |
| misc_clk_sel | input | 2 | Clock-select bits from the miscellaneous output register |
| clk_src | output | 2 | Active source: 0 fixed low, 1 fixed high, 2 programmable |
| halve_pclk | output | 1 | Pixel-clock halving flag |
| mem_n | output | 5 | Memory synthesiser N |
| mem_r | output | 3 | Memory synthesiser R |
| mem_m | output | 7 | Memory synthesiser M |
| vid_n | output | 5 | Video synthesiser N |
| vid_r | output | 3 | Video synthesiser R |
| vid_m | output | 7 | Video synthesiser M |

## Verification
The key gate is exercised three ways. Accesses are made with the key cleared, with a near-miss key of 0x07, and with the correct key. Locked reads at 0x10, 0x1A, 0x1B and 0xFF separate the zero region from the index-echo region at its exact boundary. Divider writes use all-ones and alternating patterns, which show that the N and R fields are split apart and that the M top bit is dropped. Reads of the sequence index are interleaved with locked reads of the same index, which separates a pointer that advances on every strobe from one that advances only when the read is honoured.

// File: rtl/seqx_pkg.sv
package seqx_pkg;
  localparam logic [7:0] IDX_KEY     = 8'h08;
  localparam logic [7:0] KEY_OPEN    = 8'h06;
  localparam logic [7:0] ECHO_FLOOR  = 8'h1B;
  localparam logic [7:0] IDX_MEM_LO  = 8'h10;
  localparam logic [7:0] IDX_CMD     = 8'h15;
  localparam logic [7:0] IDX_SEQ     = 8'h17;
  localparam int         NUM_PLL     = 2;
  localparam int         SEQ_DEPTH   = 4;
  localparam int         HALVE_BIT   = 4;

  typedef enum logic [1:0] {
    SRC_FIXED_LO = 2'd0,
    SRC_FIXED_HI = 2'd1,
    SRC_PROG     = 2'd2
  } clk_src_e;

  function automatic logic [7:0] seq_byte(input int unsigned pos);
    case (pos)
      0:       seq_byte = 8'h7B;
      1:       seq_byte = 8'hC0;
      2:       seq_byte = 8'h00;
      default: seq_byte = 8'hDA;
    endcase
  endfunction
endpackage

// File: rtl/seqx_key_guard.sv
module seqx_key_guard
  import seqx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] idx,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] key_q,
  output logic       open_q,
  output logic       ext_ok
);
  logic [7:0] key_d;
  logic       key_ld;

  assign key_ld = wr_en && (idx == IDX_KEY);

  always_comb begin
    key_d = key_q;
    if (key_ld) key_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_q <= '0;
    else        key_q <= key_d;
  end

  assign open_q = (key_q == KEY_OPEN);
  assign ext_ok = open_q && (idx > IDX_KEY);
endmodule

// File: rtl/seqx_pll_fields.sv
module seqx_pll_fields
  import seqx_pkg::*;
#(
  parameter logic [7:0] LO_IDX = 8'h10,
  parameter int         NW     = 5,
  parameter int         RW     = 3,
  parameter int         MW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    idx,
  input  logic          wr_ok,
  input  logic [7:0]    wdata,
  output logic [NW-1:0] n_q,
  output logic [RW-1:0] r_q,
  output logic [MW-1:0] m_q,
  output logic          hit,
  output logic [7:0]    rd
);
  localparam logic [7:0] HI_IDX = LO_IDX + 8'd1;

  logic          lo_en, hi_en;
  logic [NW-1:0] n_d;
  logic [RW-1:0] r_d;
  logic [MW-1:0] m_d;

  assign lo_en = wr_ok && (idx == LO_IDX);
  assign hi_en = wr_ok && (idx == HI_IDX);

  always_comb begin
    n_d = n_q;
    r_d = r_q;
    m_d = m_q;
    if (lo_en) begin
      n_d = wdata[NW-1:0];
      r_d = wdata[NW+RW-1:NW];
    end
    if (hi_en) m_d = wdata[MW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      r_q <= '0;
      m_q <= '0;
    end else begin
      n_q <= n_d;
      r_q <= r_d;
      m_q <= m_d;
    end
  end

  assign hit = (idx == LO_IDX) || (idx == HI_IDX);

  always_comb begin
    rd = '0;
    if (idx == LO_IDX) rd = {r_q, n_q};
    else if (idx == HI_IDX) rd = 8'(m_q);
  end
endmodule

// File: rtl/seqx_rot_seq.sv
module seqx_rot_seq
  import seqx_pkg::*;
#(
  parameter int DEPTH = SEQ_DEPTH,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [PW-1:0] ptr_q,
  output logic [7:0]    cur
);
  logic [PW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step) begin
      if (ptr_q == PW'(DEPTH - 1)) ptr_d = '0;
      else                         ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign cur = seq_byte(int'(ptr_q));
endmodule

// File: rtl/seqx_clk_regs.sv
module seqx_clk_regs
  import seqx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] idx,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  input  logic [1:0] misc_clk_sel,
  output logic [1:0] clk_src,
  output logic       halve_pclk,
  output logic [4:0] mem_n,
  output logic [2:0] mem_r,
  output logic [6:0] mem_m,
  output logic [4:0] vid_n,
  output logic [2:0] vid_r,
  output logic [6:0] vid_m
);
  localparam int PW = $clog2(SEQ_DEPTH);

  logic [7:0]    key_q;
  logic          open_q, ext_ok, wr_ok;
  logic [7:0]    cmd_q, cmd_d;
  logic          seq_step;
  logic [PW-1:0] seq_ptr;
  logic [7:0]    seq_cur;

  logic [4:0] n_arr [NUM_PLL];
  logic [2:0] r_arr [NUM_PLL];
  logic [6:0] m_arr [NUM_PLL];
  logic       hit_arr [NUM_PLL];
  logic [7:0] rd_arr [NUM_PLL];

  seqx_key_guard u_key (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wdata(wdata),
    .key_q(key_q), .open_q(open_q), .ext_ok(ext_ok)
  );

  assign wr_ok = wr_en && ext_ok;

  for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
    seqx_pll_fields #(.LO_IDX(IDX_MEM_LO + 8'(2 * g))) u_pll (
      .clk(clk), .rst_n(rst_n), .idx(idx), .wr_ok(wr_ok), .wdata(wdata),
      .n_q(n_arr[g]), .r_q(r_arr[g]), .m_q(m_arr[g]),
      .hit(hit_arr[g]), .rd(rd_arr[g])
    );
  end

  assign mem_n = n_arr[0];
  assign mem_r = r_arr[0];
  assign mem_m = m_arr[0];
  assign vid_n = n_arr[1];
  assign vid_r = r_arr[1];
  assign vid_m = m_arr[1];

  always_comb begin
    cmd_d = cmd_q;
    if (wr_ok && (idx == IDX_CMD)) cmd_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign halve_pclk = cmd_q[HALVE_BIT];

  assign seq_step = rd_en && ext_ok && (idx == IDX_SEQ);

  seqx_rot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .step(seq_step), .ptr_q(seq_ptr), .cur(seq_cur)
  );

  always_comb begin
    rdata = '0;
    if (idx == IDX_KEY) begin
      rdata = key_q;
    end else if ((idx > IDX_KEY) && !open_q) begin
      rdata = (idx < ECHO_FLOOR) ? 8'h00 : idx;
    end else if (idx > IDX_KEY) begin
      if (idx == IDX_CMD)      rdata = cmd_q;
      else if (idx == IDX_SEQ) rdata = seq_cur;
      else begin
        for (int k = 0; k < NUM_PLL; k++)
          if (hit_arr[k]) rdata = rd_arr[k];
      end
    end
  end

  always_comb begin
    case (misc_clk_sel)
      2'd0:    clk_src = SRC_FIXED_LO;
      2'd1:    clk_src = SRC_FIXED_HI;
      default: clk_src = SRC_PROG;
    endcase
  end
endmodule

// File: rtl/seqx_clk_regs_chk.sv
module seqx_clk_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] idx,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic [1:0] misc_clk_sel,
  input logic [1:0] clk_src,
  input logic       halve_pclk,
  input logic [4:0] mem_n,
  input logic [6:0] mem_m,
  input logic [7:0] key_q,
  input logic [1:0] seq_ptr
);
  logic locked;
  assign locked = (key_q != 8'h06);

  p_key_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 8'h08) |=> (key_q == $past(wdata)));

  p_locked_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && idx > 8'h08) |=> ($stable(mem_n) && $stable(mem_m) && $stable(halve_pclk)));

  p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && idx > 8'h08) |-> (rdata == ((idx < 8'h1B) ? 8'h00 : idx)));

  p_halve_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !locked && idx == 8'h15) |=> (halve_pclk == $past(wdata[4])));

  p_seq_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !locked && idx == 8'h17) |=> (seq_ptr == $past(seq_ptr) + 2'd1));

  p_seq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !locked && idx == 8'h17) |=> $stable(seq_ptr));

  p_src_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misc_clk_sel[1] |-> (clk_src == 2'd2));

  p_src_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !misc_clk_sel[1] |-> (clk_src == {1'b0, misc_clk_sel[0]}));
endmodule

bind seqx_clk_regs seqx_clk_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .misc_clk_sel(misc_clk_sel),
  .clk_src(clk_src), .halve_pclk(halve_pclk), .mem_n(mem_n), .mem_m(mem_m),
  .key_q(key_q), .seq_ptr(seq_ptr)
);

// File: tb/sim_seqx_clk_regs.sv
module sim_seqx_clk_regs;
  logic       clk, rst_n;
  logic [7:0] idx, wdata, rdata;
  logic       wr_en, rd_en;
  logic [1:0] misc_clk_sel, clk_src;
  logic       halve_pclk;
  logic [4:0] mem_n, vid_n;
  logic [2:0] mem_r, vid_r;
  logic [6:0] mem_m, vid_m;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  seqx_clk_regs u0 (
    .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .misc_clk_sel(misc_clk_sel),
    .clk_src(clk_src), .halve_pclk(halve_pclk),
    .mem_n(mem_n), .mem_r(mem_r), .mem_m(mem_m),
    .vid_n(vid_n), .vid_r(vid_r), .vid_m(vid_m)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    idx = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    idx = a; rd_en = 1;
    #1 d = rdata;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(8'h08, v);
    chk("R1 key", v, 8'h00);
    chk("R1 halve", {7'd0, halve_pclk}, 8'h00);
    chk("R1 mem_m", {1'b0, mem_m}, 8'h00);
  endtask

  task automatic t_key;
    logic [7:0] v;
    wr(8'h08, 8'h5A); rd(8'h08, v); chk("R2 key readback", v, 8'h5A);
    wr(8'h08, 8'h06); rd(8'h08, v); chk("R2 key open", v, 8'h06);
  endtask

  task automatic t_locked;
    logic [7:0] v;
    wr(8'h08, 8'h06); wr(8'h10, 8'h21);
    wr(8'h08, 8'h07); wr(8'h10, 8'hFF); wr(8'h15, 8'h10);
    chk("R3 halve unchanged", {7'd0, halve_pclk}, 8'h00);
    rd(8'h10, v); chk("R4 locked 0x10", v, 8'h00);
    rd(8'h1A, v); chk("R4 locked 0x1A", v, 8'h00);
    rd(8'h1B, v); chk("R4 locked 0x1B", v, 8'h1B);
    rd(8'hFF, v); chk("R4 locked 0xFF", v, 8'hFF);
    wr(8'h08, 8'h06);
    rd(8'h10, v); chk("R3 dropped write", v, 8'h21);
  endtask

  task automatic t_pll;
    logic [7:0] v;
    wr(8'h08, 8'h06);
    wr(8'h10, 8'hB5); wr(8'h11, 8'hFF);
    rd(8'h10, v); chk("R5 mem lo", v, 8'hB5);
    rd(8'h11, v); chk("R5 mem hi", v, 8'h7F);
    chk("R5 mem_n", {3'd0, mem_n}, 8'h15);
    chk("R5 mem_r", {5'd0, mem_r}, 8'h05);
    wr(8'h12, 8'h4A); wr(8'h13, 8'hAA);
    rd(8'h12, v); chk("R6 vid lo", v, 8'h4A);
    rd(8'h13, v); chk("R6 vid hi", v, 8'h2A);
    chk("R6 vid_n", {3'd0, vid_n}, 8'h0A);
    chk("R6 vid_r", {5'd0, vid_r}, 8'h02);
    chk("R6 vid_m", {1'b0, vid_m}, 8'h2A);
  endtask

  task automatic t_cmd;
    logic [7:0] v;
    wr(8'h15, 8'hEF); rd(8'h15, v); chk("R7 cmd", v, 8'hEF);
    chk("R7 halve clear", {7'd0, halve_pclk}, 8'h00);
    wr(8'h15, 8'h10);
    chk("R7 halve set", {7'd0, halve_pclk}, 8'h01);
  endtask

  task automatic t_seq;
    logic [7:0] v;
    logic [7:0] exp [5] = '{8'h7B, 8'hC0, 8'h00, 8'hDA, 8'h7B};
    wr(8'h08, 8'h06);
    rd(8'h17, v); chk("R8 seq 0", v, exp[0]);
    wr(8'h08, 8'h00);
    rd(8'h17, v); chk("R8 locked seq", v, 8'h00);
    rd(8'h17, v);
    wr(8'h08, 8'h06);
    for (int i = 1; i < 5; i++) begin
      rd(8'h17, v); chk("R8 seq step", v, exp[i]);
    end
  endtask

  task automatic t_src;
    logic [1:0] e [4] = '{2'd0, 2'd1, 2'd2, 2'd2};
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); misc_clk_sel = 2'(s);
      #1 chk("R9 clk_src", {6'd0, clk_src}, {6'd0, e[s]});
    end
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    wr(8'h08, 8'h06);
    wr(8'h14, 8'hFF); rd(8'h14, v); chk("R10 0x14", v, 8'h00);
    wr(8'h16, 8'hFF); rd(8'h16, v); chk("R10 0x16", v, 8'h00);
    wr(8'h20, 8'hFF); rd(8'h20, v); chk("R10 0x20", v, 8'h00);
    wr(8'h03, 8'hFF); rd(8'h03, v); chk("R10 0x03", v, 8'h00);
    rd(8'h10, v); chk("R10 no side write", v, 8'hB5);
  endtask

  initial begin
    rst_n = 0; idx = 0; wdata = 0; wr_en = 0; rd_en = 0; misc_clk_sel = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_key();
    t_locked();
    t_pll();
    t_cmd();
    t_seq();
    t_src();
    t_unimpl();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule